// File: doc/BRIEF.md
# Punched Card Reader Sequencer

This block sits between a host and a punched-card reader. When the host asks for a card, it checks that the reader is ready and then issues a one-cycle pick command. It then takes in the reader's column strobes one at a time and forwards each of the 80 column values to the host's buffer as an indexed write.

The block does not go idle as soon as the last column arrives. It first waits for the reader's busy line to be seen high and then to fall. After that it waits a fixed settle interval, because the hopper-empty line only becomes valid several milliseconds after busy drops. At the end of the interval it reports completion and decides whether the hopper has run out. An empty hopper places the block in a latched last-card condition. The operator clears that condition with the start button, either to end the deck or to carry on after reloading cards.

All reader status lines, the column strobe and the start button are asynchronous, so each one passes through a two-flop synchroniser. Column data is streamed to the host as a valid-only write beat carrying an index and a value. There is no ready signal on that path: the reader cannot be paused in the middle of a card, so the host must accept every beat in the cycle it is offered. The host request input is synchronous to the clock.

Top module: `cr_reader_adapter`

## Requirements
- R1: After reset the block is idle, `rdr_pick`, `host_done`, `host_deck_end` and `col_wr_valid` are low, and `status` is 0. The `status` bits are: [5:3] state code (idle=0, columns=1, wait-busy-high=2, wait-busy-low=3, settle=4, last-card=5), [2] hopper latched, [1] not-ready error, [0] read active.
- R2: A `host_rd_req` pulse in idle while the reader is ready gives exactly one `rdr_pick` pulse, clears the error bit, sets read active and enters the columns state. A request while the reader is not ready sets the error bit, issues no pick and leaves the block idle.
- R3: Each synchronised rising edge of `rdr_col_strobe` in the columns state gives one `col_wr_valid` beat. The beats carry indices 0 to 79 in order, each with the `rdr_col_data` value present at that strobe. No column is dropped or repeated.
- R4: After the 80th column the block stays in state 2 until busy is seen high. It then stays in state 3 until busy falls.
- R5: The fall of busy starts a settle interval of SETTLE_CYC cycles in state 4. Hopper-empty is sampled only when that interval ends, so a rise inside the interval is still caught.
- R6: At the end of the settle interval `host_done` pulses for exactly one cycle and the read-active bit clears.
- R7: If hopper-empty is high at the end of settle, the block enters state 5 with the hopper bit set. It stays there, issuing no pick, whatever ready and hopper-empty do, until start rises.
- R8: In state 5 a start rise returns the block to idle and clears the hopper bit. If hopper-empty is still high at that moment, `host_deck_end` pulses for one cycle; after a reload (hopper-empty low) it does not.
- R9: `host_rd_req` is ignored outside the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rdr_ready | input | 1 | Reader ready (asynchronous) |
| rdr_busy | input | 1 | Reader mechanism busy (asynchronous) |
| rdr_hopper_empty | input | 1 | Hopper empty (asynchronous) |
| rdr_col_strobe | input | 1 | Column available strobe (asynchronous) |
| rdr_col_data | input | 12 | Column value, stable while the strobe is high |
| rdr_pick | output | 1 | One-cycle pick command to the reader |
| op_start | input | 1 | Operator start button (asynchronous) |
| host_rd_req | input | 1 | Host read request pulse |
| host_done | output | 1 | One-cycle card-complete pulse |
| host_deck_end | output | 1 | One-cycle end-of-deck pulse |
| col_wr_valid | output | 1 | Column write beat valid |
| col_wr_idx | output | 7 | Column index 0..79 |
| col_wr_data | output | 12 | Column value |
| status | output | 6 | State code and flags (layout given in R1) |

## Verification
The bench targets the end-of-card ordering. A design that returned to idle at the 80th column would report done before busy moved. A design that sampled hopper-empty as soon as busy fell would miss a hopper that empties partway through the settle interval and would never enter the last-card state. Each card is checked by the column scoreboard, so a dropped or repeated strobe shows up as a count or index mismatch. The bench also reloads the reader while the block is in the last-card state. A design that cleared the hopper latch early, or that restarted reading on ready alone, would issue an extra pick or leave that state. Start is then pressed with and without a reload, to check that end-of-deck is flagged only in the first case.

// File: rtl/cr_pkg.sv
package cr_pkg;
  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_COLS    = 3'd1,
    S_TAIL_HI = 3'd2,
    S_TAIL_LO = 3'd3,
    S_SETTLE  = 3'd4,
    S_LAST    = 3'd5
  } cr_state_e;
endpackage

// File: rtl/cr_sync.sv
module cr_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cr_col_counter.sv
module cr_col_counter #(
  parameter int COLS = 80,
  localparam int IW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          beat,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = beat && (idx == IW'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) idx <= '0;
    else if (beat)  idx <= last ? '0 : idx + 1'b1;
  end

  // R3: the index never leaves the column range
  a_r3_idx_range: assert property (@(posedge clk) disable iff (rst)
    idx < IW'(COLS));
endmodule

// File: rtl/cr_settle_timer.sv
module cr_settle_timer #(
  parameter int CYC = 300000,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic expired
);
  logic          active;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      cnt     <= '0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (start) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (cnt == CW'(CYC - 1)) begin
          active  <= 1'b0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R5: expiry only follows a running interval
  a_r5_expiry_after_run: assert property (@(posedge clk) disable iff (rst)
    expired |-> $past(active));
endmodule

// File: rtl/cr_reader_adapter.sv
module cr_reader_adapter
  import cr_pkg::*;
#(
  parameter int COLS       = 80,
  parameter int COL_W      = 12,
  parameter int SETTLE_CYC = 300000,
  localparam int IW = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rdr_ready,
  input  logic             rdr_busy,
  input  logic             rdr_hopper_empty,
  input  logic             rdr_col_strobe,
  input  logic [COL_W-1:0] rdr_col_data,
  output logic             rdr_pick,
  input  logic             op_start,
  input  logic             host_rd_req,
  output logic             host_done,
  output logic             host_deck_end,
  output logic             col_wr_valid,
  output logic [IW-1:0]    col_wr_idx,
  output logic [COL_W-1:0] col_wr_data,
  output logic [5:0]       status
);
  cr_state_e state;
  logic [4:0] raw_in, syn;
  logic rdy_s, busy_s, hop_s, stb_s, start_s;
  logic busy_prev, stb_prev, start_prev;
  logic col_rise, busy_fell, start_rise;
  logic hop_latch, err_nr, req_active;
  logic beat, col_last, settle_done;
  logic [IW-1:0] cur_idx;

  assign raw_in = {rdr_ready, rdr_busy, rdr_hopper_empty, rdr_col_strobe, op_start};

  cr_sync #(.W(5)) u_sync (.clk(clk), .rst(rst), .d(raw_in), .q(syn));
  assign {rdy_s, busy_s, hop_s, stb_s, start_s} = syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_prev  <= 1'b0;
      stb_prev   <= 1'b0;
      start_prev <= 1'b0;
    end else begin
      busy_prev  <= busy_s;
      stb_prev   <= stb_s;
      start_prev <= start_s;
    end
  end

  assign col_rise   = stb_s & ~stb_prev;
  assign busy_fell  = ~busy_s & busy_prev;
  assign start_rise = start_s & ~start_prev;
  assign beat       = (state == S_COLS) && col_rise;

  cr_col_counter #(.COLS(COLS)) u_cnt (
    .clk(clk), .rst(rst), .clr(state == S_IDLE), .beat(beat),
    .idx(cur_idx), .last(col_last)
  );

  cr_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .start((state == S_TAIL_LO) && busy_fell),
    .expired(settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      rdr_pick      <= 1'b0;
      host_done     <= 1'b0;
      host_deck_end <= 1'b0;
      col_wr_valid  <= 1'b0;
      col_wr_idx    <= '0;
      col_wr_data   <= '0;
      hop_latch     <= 1'b0;
      err_nr        <= 1'b0;
      req_active    <= 1'b0;
    end else begin
      rdr_pick      <= 1'b0;
      host_done     <= 1'b0;
      host_deck_end <= 1'b0;
      col_wr_valid  <= 1'b0;
      unique case (state)
        S_IDLE: if (host_rd_req) begin
          if (rdy_s) begin
            rdr_pick   <= 1'b1;
            err_nr     <= 1'b0;
            req_active <= 1'b1;
            state      <= S_COLS;
          end else begin
            err_nr <= 1'b1;
          end
        end
        S_COLS: if (beat) begin
          col_wr_valid <= 1'b1;
          col_wr_idx   <= cur_idx;
          col_wr_data  <= rdr_col_data;
          if (col_last) state <= S_TAIL_HI;
        end
        S_TAIL_HI: if (busy_s) state <= S_TAIL_LO;
        S_TAIL_LO: if (busy_fell) state <= S_SETTLE;
        S_SETTLE: if (settle_done) begin
          host_done  <= 1'b1;
          req_active <= 1'b0;
          if (hop_s) begin
            hop_latch <= 1'b1;
            state     <= S_LAST;
          end else begin
            state <= S_IDLE;
          end
        end
        S_LAST: if (start_rise) begin
          hop_latch     <= 1'b0;
          host_deck_end <= hop_s;
          state         <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign status = {state, hop_latch, err_nr, req_active};

  // R1: reset always lands in idle with the hopper latch clear
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (state == S_IDLE && !hop_latch && !rdr_pick));
  // R2: a pick is only issued when the synchronised ready was high
  a_r2_pick_ready: assert property (@(posedge clk) disable iff (rst)
    rdr_pick |-> $past(rdy_s));
  // R4: the busy-high wait holds until busy is seen
  a_r4_tail_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_TAIL_HI && !busy_s) |=> state == S_TAIL_HI);
  // R5: the settle timer only expires while settling
  a_r5_settle_only: assert property (@(posedge clk) disable iff (rst)
    settle_done |-> state == S_SETTLE);
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);
  // R7: last-card state is left only on a start edge
  a_r7_last_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_LAST && !start_rise) |=> (state == S_LAST && hop_latch));
endmodule

// File: tb/cr_reader_adapter_bench.sv
module cr_reader_adapter_bench;
  localparam int COLS = 80;
  localparam int SETTLE = 50;

  logic clk = 0, rst = 1;
  logic rdr_ready = 0, rdr_busy = 0, rdr_hop = 0, rdr_stb = 0, op_start = 0, host_rd_req = 0;
  logic [11:0] rdr_col_data = '0;
  logic rdr_pick, host_done, host_deck_end, col_wr_valid;
  logic [6:0] col_wr_idx;
  logic [11:0] col_wr_data;
  logic [5:0] status;

  always #10 clk = ~clk;

  cr_reader_adapter #(.COLS(COLS), .COL_W(12), .SETTLE_CYC(SETTLE)) u_cr_reader_adapter (
    .clk(clk), .rst(rst), .rdr_ready(rdr_ready), .rdr_busy(rdr_busy),
    .rdr_hopper_empty(rdr_hop), .rdr_col_strobe(rdr_stb), .rdr_col_data(rdr_col_data),
    .rdr_pick(rdr_pick), .op_start(op_start), .host_rd_req(host_rd_req),
    .host_done(host_done), .host_deck_end(host_deck_end), .col_wr_valid(col_wr_valid),
    .col_wr_idx(col_wr_idx), .col_wr_data(col_wr_data), .status(status)
  );

  int checks = 0, fails = 0;
  int picks = 0, dones = 0, ends = 0, beats = 0;
  logic [18:0] exp_q[$];
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: counts pulses and scores column beats against the driver's queue
  always @(negedge clk) if (!rst) begin
    if (rdr_pick) picks++;
    if (host_done) dones++;
    if (host_deck_end) ends++;
    if (col_wr_valid) begin
      beats++;
      if (exp_q.size() == 0) check("R3 unexpected beat", {13'd0, col_wr_idx, col_wr_data}, 32'hFFFFFFFF);
      else check("R3 column beat", {13'd0, col_wr_idx, col_wr_data}, {13'd0, exp_q.pop_front()});
    end
  end

  task automatic request();
    host_rd_req = 1; cyc(1); host_rd_req = 0; cyc(6);
  endtask

  task automatic feed_card(input logic [11:0] base, input bit poke_req);
    for (int i = 0; i < COLS; i++) begin
      logic [11:0] v;
      v = base + 12'(i * 37);
      exp_q.push_back({7'(i), v});
      rdr_col_data = v; cyc(1);
      rdr_stb = 1; cyc(4);
      rdr_stb = 0; cyc(3);
      if (poke_req && i == 40) begin host_rd_req = 1; cyc(1); host_rd_req = 0; end
    end
    cyc(8);
  endtask

  task automatic press_start();
    op_start = 1; cyc(6); op_start = 0; cyc(6);
  endtask

  initial begin
    cyc(4); rst = 0; cyc(2);
    check("R1 status after reset", status, 0);
    check("R1 outputs after reset", {rdr_pick, host_done, host_deck_end, col_wr_valid}, 0);

    // not-ready request
    request();
    check("R2 error bit on not-ready", status, 6'b000_010);
    check("R2 no pick on not-ready", picks, 0);

    // card 1: busy stays low during columns, hopper stays full
    rdr_ready = 1; cyc(4);
    request();
    check("R2 single pick", picks, 1);
    check("R2 columns state, error cleared", status, 6'b001_001);
    feed_card(12'h100, 1);
    check("R9 request ignored mid-card", picks, 1);
    check("R3 column count card 1", beats, 80);
    check("R4 wait busy high", status[5:3], 2);
    check("R6 no done before busy", dones, 0);
    rdr_ready = 0; rdr_busy = 1; cyc(6);
    check("R4 wait busy low", status[5:3], 3);
    rdr_busy = 0; cyc(6);
    check("R5 settling", status[5:3], 4);
    cyc(SETTLE + 6);
    check("R6 one done", dones, 1);
    check("R6 idle, read inactive", status, 0);

    // card 2: hopper rises partway through settle
    rdr_ready = 1; cyc(4);
    request();
    feed_card(12'h200, 0);
    rdr_ready = 0; rdr_busy = 1; cyc(6);
    rdr_busy = 0; cyc(20);
    rdr_hop = 1; cyc(SETTLE);
    check("R5 late hopper caught", status, 6'b101_100);
    check("R6 done card 2", dones, 2);
    cyc(200);
    rdr_hop = 0; rdr_ready = 1; cyc(100);
    check("R7 latched through reload", status, 6'b101_100);
    check("R7 no pick on reload", picks, 2);
    press_start();
    check("R8 resume to idle", status, 0);
    check("R8 no deck end on resume", ends, 0);

    // card 3: busy already high during columns, hopper empties, start ends deck
    request();
    rdr_busy = 1;
    feed_card(12'h300, 0);
    check("R4 busy already high passes", status[5:3], 3);
    rdr_ready = 0; rdr_busy = 0; cyc(4); rdr_hop = 1;
    cyc(SETTLE + 10);
    check("R7 last card state", status[5:3], 5);
    press_start();
    check("R8 deck end pulse", ends, 1);
    check("R8 idle after deck end", status, 0);
    check("R3 total beats", beats, 240);
    check("R3 scoreboard drained", exp_q.size(), 0);
    check("R6 total dones", dones, 3);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule